// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address sequencer of a single DMA channel. One start pulse loads a job: a word-granular origin address, the words to move per line, the line pitch (the line words plus any gap words), the line count less one, a transfer direction and a burst flag. The block then presents one word address per beat. The address advances only when the consumer accepts the beat.

A job with a line length of zero runs in loop mode. In loop mode the block walks a contiguous area of pitch × (line count) words. At the end of the area it returns to the origin, and it keeps going until it is stopped. The area is split into two equal halves, and the block signals the end of each half on every pass. A job with a nonzero line length walks a rectangle line by line and finishes with a one-cycle done pulse. A synchronous stop input abandons any job immediately.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `beat_req`, `done` and `half_evt` are low.
- R2: A `start` pulse accepted in idle raises `beat_req` on the next cycle. The first `beat_addr` is then `start_addr`. `xfer_dir` and `xfer_burst` show the captured `cfg_dir` and `cfg_burst` for the whole job: direction 1 is memory to device and 0 is device to memory, and burst 1 selects 4-word bursts while 0 selects single words.
- R3: While `beat_req` is high and `beat_ack` is low, `beat_addr` holds its value and `beat_req` stays high.
- R4: Within a line, each accepted beat advances `beat_addr` by one word.
- R5: After `cfg_xlen` beats of a line have been accepted, the next address is that line's first address plus `cfg_pitch`.
- R6: With a nonzero `cfg_xlen`, the job ends after the last beat of line `cfg_ylen`+1 is accepted. On the following cycle `done` is high for exactly one cycle and `beat_req` is low.
- R7: With `cfg_xlen` zero, the block increments through pitch × (`cfg_ylen`+1) words. After the last word it returns to `start_addr`, and it never raises `done`. The area size is assumed even and at least 2.
- R8: In loop mode, `half_evt` pulses for one cycle after the beat that ends the first half is accepted, with `half_idx`=0. It pulses again after the beat that ends the area is accepted, with `half_idx`=1. This repeats on every pass.
- R9: `stop` high at a clock edge makes the block idle from the next cycle, with no `done` and no `half_evt`. A `start` in the same cycle is ignored.
- R10: A `start` while a job is running is ignored, and the running address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the job fields and begin (accepted in idle only) |
| start_addr | input | AW | Origin word address |
| cfg_xlen | input | XW | Words per line; zero selects loop mode |
| cfg_pitch | input | XW | Line-to-line distance in words |
| cfg_ylen | input | YW | Number of lines minus one |
| cfg_dir | input | 1 | 1 memory to device, 0 device to memory |
| cfg_burst | input | 1 | 1 four-word bursts, 0 single words |
| stop | input | 1 | Synchronous abort to idle |
| beat_ack | input | 1 | Consumer accepts the current beat |
| beat_req | output | 1 | A beat address is offered |
| beat_addr | output | AW | Current word address |
| xfer_dir | output | 1 | Captured direction |
| xfer_burst | output | 1 | Captured burst mode |
| done | output | 1 | One-cycle end-of-job pulse |
| half_evt | output | 1 | One-cycle half-boundary pulse in loop mode |
| half_idx | output | 1 | Which half just ended (0 first, 1 second) |

## Verification
The bench targets line ends where the pitch exceeds the line length. A design that adds one instead of jumping would land inside the gap. It also runs single-word jobs, where the first beat is also the last; an off-by-one limit would run on or finish a line early. Loop runs with stalled acknowledges check that the half event comes exactly at the midpoint and the end of the area, that the address returns to the origin, and that `done` never appears. Stop and start arriving in the same cycle, and start pulses during a running job, check that a stray start cannot restart the sequence.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dma2d_st_e;
endpackage

// File: rtl/dma2d_cnt.sv
// Wrapping up-counter: clears on clr, counts on inc, returns to zero at lim.
module dma2d_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic         at_lim
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign at_lim = (cnt_q == lim);

  always_comb begin
    cnt_en = clr | inc;
    if (clr || at_lim) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma2d_addr_step.sv
// Holds the current address, the current line start and the origin.
module dma2d_addr_step #(
  parameter int AW = 30,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic          line_end,
  input  logic          wrap,
  input  logic [PW-1:0] pitch,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d, base_q, base_d, org_q;
  logic [AW-1:0] next_base;
  logic          step_en;

  assign next_base = base_q + AW'(pitch);

  always_comb begin
    step_en = load | adv;
    addr_d  = addr + 1'b1;
    base_d  = base_q;
    if (load) begin
      addr_d = load_addr;
      base_d = load_addr;
    end else if (wrap) begin
      addr_d = org_q;
    end else if (line_end) begin
      addr_d = next_base;
      base_d = next_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      base_q <= '0;
      org_q  <= '0;
    end else begin
      if (step_en) begin
        addr   <= addr_d;
        base_q <= base_d;
      end
      if (load) org_q <= load_addr;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [XW-1:0] cfg_xlen,
  input  logic [XW-1:0] cfg_pitch,
  input  logic [YW-1:0] cfg_ylen,
  input  logic          cfg_dir,
  input  logic          cfg_burst,
  input  logic          stop,
  input  logic          beat_ack,
  output logic          beat_req,
  output logic [AW-1:0] beat_addr,
  output logic          xfer_dir,
  output logic          xfer_burst,
  output logic          done,
  output logic          half_evt,
  output logic          half_idx
);
  localparam int AR = XW + YW;

  dma2d_st_e     st_q, st_d;
  logic [XW-1:0] xlen_q, pitch_q;
  logic [YW-1:0] ylen_q;
  logic [AR-1:0] half_m1_q, half_m1_d;
  logic          loop_q, dir_q, burst_q, side_q;
  logic          done_d, evt_d;
  logic          go, adv, x_at, y_at, h_at, eol, eob, wrap, hit_half;

  assign go       = start && (st_q == ST_IDLE) && !stop;
  assign adv      = (st_q == ST_RUN) && beat_ack && !stop;
  assign eol      = !loop_q && x_at;
  assign eob      = eol && y_at;
  assign hit_half = loop_q && h_at;
  assign wrap     = hit_half && side_q;

  always_comb begin
    half_m1_d = ((AR'(cfg_pitch) * (AR'(cfg_ylen) + 1'b1)) >> 1) - 1'b1;
    done_d    = adv && eob;
    evt_d     = adv && hit_half;
    st_d      = st_q;
    if (stop)        st_d = ST_IDLE;
    else if (go)     st_d = ST_RUN;
    else if (done_d) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      xlen_q    <= '0;
      pitch_q   <= '0;
      ylen_q    <= '0;
      half_m1_q <= '0;
      loop_q    <= 1'b0;
      dir_q     <= 1'b0;
      burst_q   <= 1'b0;
      side_q    <= 1'b0;
      done      <= 1'b0;
      half_evt  <= 1'b0;
      half_idx  <= 1'b0;
    end else begin
      st_q     <= st_d;
      done     <= done_d;
      half_evt <= evt_d;
      if (go) begin
        xlen_q    <= cfg_xlen;
        pitch_q   <= cfg_pitch;
        ylen_q    <= cfg_ylen;
        half_m1_q <= half_m1_d;
        loop_q    <= (cfg_xlen == '0);
        dir_q     <= cfg_dir;
        burst_q   <= cfg_burst;
        side_q    <= 1'b0;
      end else if (evt_d) begin
        side_q <= ~side_q;
      end
      if (evt_d) half_idx <= side_q;
    end
  end

  dma2d_cnt #(.W(XW)) u_xcnt (
    .clk(clk), .rst_n(rst_n), .clr(go), .inc(adv && !loop_q),
    .lim(xlen_q - 1'b1), .at_lim(x_at));

  dma2d_cnt #(.W(YW)) u_ycnt (
    .clk(clk), .rst_n(rst_n), .clr(go), .inc(adv && eol),
    .lim(ylen_q), .at_lim(y_at));

  dma2d_cnt #(.W(AR)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(go), .inc(adv && loop_q),
    .lim(half_m1_q), .at_lim(h_at));

  dma2d_addr_step #(.AW(AW), .PW(XW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(go), .load_addr(start_addr),
    .adv(adv), .line_end(eol), .wrap(wrap), .pitch(pitch_q),
    .addr(beat_addr));

  assign beat_req   = (st_q == ST_RUN);
  assign xfer_dir   = dir_q;
  assign xfer_burst = burst_q;

  AST_ADDR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_req && !beat_ack && !stop |=> beat_req && $stable(beat_addr)); // R3
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_req && beat_ack && !stop && !loop_q && !x_at
      |=> beat_addr == $past(beat_addr) + 1'b1); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_req && !loop_q); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_LOOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q && beat_req |=> !done); // R7
  AST_EVT_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |-> loop_q); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !beat_req && !done && !half_evt); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    beat_req && start && !beat_ack && !stop |=> beat_req && $stable(beat_addr)); // R10
endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  localparam int AW = 30;
  localparam int XW = 12;
  localparam int YW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [XW-1:0] cfg_xlen = '0;
  logic [XW-1:0] cfg_pitch = '0;
  logic [YW-1:0] cfg_ylen = '0;
  logic          cfg_dir = 1'b0;
  logic          cfg_burst = 1'b0;
  logic          stop = 1'b0;
  logic          beat_ack = 1'b0;
  logic          beat_req, xfer_dir, xfer_burst, done, half_evt, half_idx;
  logic [AW-1:0] beat_addr;

  dma2d_addr_gen #(.AW(AW), .XW(XW), .YW(YW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .cfg_xlen(cfg_xlen), .cfg_pitch(cfg_pitch), .cfg_ylen(cfg_ylen),
    .cfg_dir(cfg_dir), .cfg_burst(cfg_burst), .stop(stop),
    .beat_ack(beat_ack), .beat_req(beat_req), .beat_addr(beat_addr),
    .xfer_dir(xfer_dir), .xfer_burst(xfer_burst), .done(done),
    .half_evt(half_evt), .half_idx(half_idx));

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R1";
  int    ack_pct = 100;

  // behavioural reference state
  logic          m_act, m_done, m_evt, m_idx, m_loop, m_dir, m_burst;
  logic [AW-1:0] m_addr, m_base, m_org;
  int            m_x, m_y, m_off, m_xlen, m_pitch, m_ylen, m_area;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_evt = 0; m_idx = 0; m_loop = 0;
      m_dir = 0; m_burst = 0; m_addr = '0; m_base = '0; m_org = '0;
      m_x = 0; m_y = 0; m_off = 0; m_xlen = 0; m_pitch = 0; m_ylen = 0; m_area = 0;
    end else begin
      m_done = 0;
      m_evt  = 0;
      if (stop) begin
        m_act = 0;
      end else if (!m_act && start) begin
        m_act = 1; m_addr = start_addr; m_base = start_addr; m_org = start_addr;
        m_x = 0; m_y = 0; m_off = 0;
        m_xlen = int'(cfg_xlen); m_pitch = int'(cfg_pitch); m_ylen = int'(cfg_ylen);
        m_area = m_pitch * (m_ylen + 1);
        m_loop = (m_xlen == 0); m_dir = cfg_dir; m_burst = cfg_burst;
      end else if (m_act && beat_ack) begin
        if (m_loop) begin
          if (m_off == m_area - 1) begin
            m_addr = m_org; m_off = 0; m_evt = 1; m_idx = 1;
          end else begin
            if (m_off == m_area / 2 - 1) begin m_evt = 1; m_idx = 0; end
            m_addr = m_addr + 1; m_off = m_off + 1;
          end
        end else if (m_x == m_xlen - 1) begin
          m_x = 0;
          if (m_y == m_ylen) begin
            m_act = 0; m_done = 1;
          end else begin
            m_y = m_y + 1; m_base = m_base + AW'(m_pitch); m_addr = m_base;
          end
        end else begin
          m_addr = m_addr + 1; m_x = m_x + 1;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("beat_req", AW'(beat_req), AW'(m_act));
      chk("done", AW'(done), AW'(m_done));
      chk("half_evt", AW'(half_evt), AW'(m_evt));
      if (m_act) begin
        chk("beat_addr", beat_addr, m_addr);
        chk("xfer_dir", AW'(xfer_dir), AW'(m_dir));
        chk("xfer_burst", AW'(xfer_burst), AW'(m_burst));
      end
      if (m_evt) chk("half_idx", AW'(half_idx), AW'(m_idx));
    end
  end

  // acknowledge generator
  always @(negedge clk) begin
    beat_ack <= (($urandom % 100) < ack_pct);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic launch(input int a, input int x, input int p, input int y,
                        input logic d, input logic b);
    @(negedge clk);
    start <= 1'b1; start_addr <= AW'(a); cfg_xlen <= XW'(x);
    cfg_pitch <= XW'(p); cfg_ylen <= YW'(y); cfg_dir <= d; cfg_burst <= b;
    @(negedge clk);
    start <= 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!m_act) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic halt();
    @(negedge clk);
    stop <= 1'b1;
    @(negedge clk);
    stop <= 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("reset beat_req", AW'(beat_req), '0);
    chk("reset done", AW'(done), '0);
    chk("reset half_evt", AW'(half_evt), '0);

    tag = "R2"; ack_pct = 100;
    launch(100, 4, 4, 0, 1'b1, 1'b0);
    wait_idle();
    launch(300, 2, 2, 1, 1'b0, 1'b1);
    wait_idle();

    tag = "R3"; ack_pct = 40;
    launch(200, 3, 3, 1, 1'b1, 1'b1);
    wait_idle();

    tag = "R4"; ack_pct = 70;
    launch(1000, 9, 9, 0, 1'b0, 1'b0);
    wait_idle();

    tag = "R5"; ack_pct = 60;
    launch(64, 5, 8, 3, 1'b0, 1'b1);
    wait_idle();
    ack_pct = 100;
    launch(4000, 3, 20, 4, 1'b1, 1'b0);
    wait_idle();

    tag = "R6"; ack_pct = 100;
    launch(7, 1, 1, 0, 1'b1, 1'b1);
    wait_idle();
    launch(50, 2, 5, 2, 1'b0, 1'b0);
    wait_idle();
    ack_pct = 50;
    launch(90, 1, 3, 4, 1'b1, 1'b0);
    wait_idle();

    tag = "R7"; ack_pct = 60;
    launch(500, 0, 1, 7, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    halt();

    tag = "R8"; ack_pct = 100;
    launch(800, 0, 2, 5, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    halt();
    ack_pct = 30;
    launch(900, 0, 1, 1, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    halt();

    tag = "R9"; ack_pct = 100;
    launch(1200, 4, 4, 9, 1'b0, 1'b0);
    repeat (7) @(negedge clk);
    stop <= 1'b1; start <= 1'b1; start_addr <= AW'(77); cfg_xlen <= XW'(2);
    @(negedge clk);
    stop <= 1'b0; start <= 1'b0;
    repeat (4) @(negedge clk);
    launch(1300, 3, 3, 2, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    halt();

    tag = "R10"; ack_pct = 50;
    launch(2000, 4, 6, 3, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    start <= 1'b1; start_addr <= AW'(5); cfg_xlen <= XW'(1);
    cfg_pitch <= XW'(1); cfg_ylen <= '0; cfg_dir <= 1'b0; cfg_burst <= 1'b0;
    repeat (3) @(negedge clk);
    start <= 1'b0;
    wait_idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule